// File: doc/BRIEF.md
# Legacy Paravirtual Device Register Block

This block is the register face of a legacy paravirtual I/O device that sits behind a small I/O-space window. A single-access-per-cycle slave port carries an offset, a byte count (1, 2 or 4), write data and read/write strobes; read data is returned combinationally in the same cycle as the read strobe. Inside the window the block keeps the feature words that the host offers and the guest accepts, a table of ring base addresses (one per queue, chosen by a queue selector), the device status byte and an interrupt status byte whose bit 0 drives a level interrupt.

Queue sizes come in from the device core as a flat vector and are only readable. Writing the notify register produces a one-cycle kick toward the ring engine, carrying the queue index that was written. A used-buffer event from the device core raises the interrupt; reading the interrupt status acknowledges it. Every access at offset 20 or above is forwarded, with its offset rebased to zero, to a device-specific configuration port outside the block.

Top module: `pvdev_regs`

## Requirements
- R1: A read at offset 0 returns the device feature input OR-ed with bits 24, 28 and 30 forced to one; writes there change nothing.
- R2: A write at offset 4 stores the write data as the accepted feature word, unless bit 30 of the data is set, in which case the fallback feature input is stored; a read at offset 4 and the `feat_out` port return the stored word.
- R3: A write at offset 8 stores the data as the page number of the currently selected queue; a read at offset 8 returns it, and `sel_qaddr` shows that page number shifted left by 12 with zeros below.
- R4: A write at offset 14 whose low 16 bits are below NQ changes the queue selector; any larger value leaves the selector unchanged; a read at offset 14 returns the selector.
- R5: A read at offset 12 returns the 16-bit size of the selected queue, taken from slice [16*sel +: 16] of `qsize_in`.
- R6: A write at offset 16 makes `kick` high for exactly the next cycle, with `kick_q` equal to the low 16 bits written.
- R7: A write at offset 18 stores the low 8 bits as device status (readable at offset 18 and on `dev_status`); when those bits are zero, the accepted features, all queue page numbers, the selector and the interrupt status are cleared at the same edge and `dev_reset` is high for the next cycle.
- R8: A read at offset 19 returns the interrupt status byte and clears it at the end of that access; `irq` equals bit 0 of the interrupt status, so it falls in the cycle after the read.
- R9: A cycle with `used_evt` high sets interrupt status bit 0 at the next edge, even when the same cycle reads offset 19 or writes zero to the status.
- R10: For offsets of 20 and above, `cfg_rd`/`cfg_wr` mirror the bus strobes, `cfg_addr` is the offset minus 20, `cfg_size` and `cfg_wdata` pass through, and read data comes from `cfg_rdata`; below 20 both config strobes stay low.
- R11: A read from an offset below 20 that is not the start of a register (1-3, 5-7, 9-11, 13, 15, 17) returns all ones.
- R12: After reset, status, features, selector, all page numbers and interrupt status are zero, and `irq`, `kick` and `dev_reset` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Offset within the window |
| bus_size | input | 3 | Access size in bytes (1, 2 or 4) |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid in the cycle of the read strobe |
| dev_feat | input | 32 | Features the device core offers |
| fallback_feat | input | 32 | Feature set used when the guest signals a failed negotiation |
| qsize_in | input | 16*NQ | Size of each queue, queue n in bits [16n +: 16] |
| used_evt | input | 1 | Used-buffer event from the device core |
| feat_out | output | 32 | Accepted feature word |
| dev_status | output | 8 | Device status byte |
| dev_reset | output | 1 | One-cycle pulse after a zero status write |
| sel_qaddr | output | PA_W | Ring base address of the selected queue |
| kick | output | 1 | One-cycle queue notification |
| kick_q | output | 16 | Queue index carried by the notification |
| irq | output | 1 | Level interrupt |
| cfg_addr | output | ADDR_W | Rebased offset into the configuration area |
| cfg_size | output | 3 | Access size toward the configuration area |
| cfg_wdata | output | 32 | Write data toward the configuration area |
| cfg_wr | output | 1 | Configuration write strobe |
| cfg_rd | output | 1 | Configuration read strobe |
| cfg_rdata | input | 32 | Configuration read data |

## Verification
The bench goes after the collisions between the event input and the two clearing paths: a design that let the read acknowledge or the zero-status reset win would drop an interrupt the guest never saw, showing up as `irq` low after a same-cycle event. It writes out-of-range selectors (NQ and above) and then touches page numbers, so a selector that wrapped or latched the bad value would land a page in the wrong queue and show a wrong `sel_qaddr`. It sends a feature write with bit 30 set to catch a block that stored the raw word, reads the odd offsets between registers to catch a decoder that matched on masked address bits, and reads the interrupt byte twice in a row to confirm the first read cleared it while returning the old value.

// File: rtl/pvdev_pkg.sv
// pvdev_pkg: shared constants and types of the paravirtual device register
// block. Offsets and forced feature bit positions are behaviour that the
// guest driver depends on, so they live here in one place.
package pvdev_pkg;

    localparam int OFS_HOSTF  = 0;
    localparam int OFS_GUESTF = 4;
    localparam int OFS_QPAGE  = 8;
    localparam int OFS_QSIZE  = 12;
    localparam int OFS_QSEL   = 14;
    localparam int OFS_NOTIFY = 16;
    localparam int OFS_STATUS = 18;
    localparam int OFS_ISR    = 19;
    localparam int OFS_CFG    = 20;

    localparam int FBIT_NOTIFY_EMPTY = 24;
    localparam int FBIT_INDIRECT     = 28;
    localparam int FBIT_BAD_NEG      = 30;

    localparam int PAGE_SHIFT = 12;

    // Register targeted by one bus access.
    typedef enum logic [3:0] {
        RS_HOSTF,
        RS_GUESTF,
        RS_QPAGE,
        RS_QSIZE,
        RS_QSEL,
        RS_NOTIFY,
        RS_STATUS,
        RS_ISR,
        RS_CFG,
        RS_NONE
    } reg_sel_e;

endpackage

// File: rtl/pvdev_decode.sv
// pvdev_decode: maps a window offset to the register it addresses.
// Assumes a register is hit only at its first byte; every other offset below
// the configuration area is unmapped. Purely combinational.
module pvdev_decode
    import pvdev_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);

    // Exact-offset match below the config area, range match above it.
    always_comb begin
        if (addr >= ADDR_W'(OFS_CFG)) begin
            sel = RS_CFG;
        end else begin
            case (addr)
                ADDR_W'(OFS_HOSTF):  sel = RS_HOSTF;
                ADDR_W'(OFS_GUESTF): sel = RS_GUESTF;
                ADDR_W'(OFS_QPAGE):  sel = RS_QPAGE;
                ADDR_W'(OFS_QSIZE):  sel = RS_QSIZE;
                ADDR_W'(OFS_QSEL):   sel = RS_QSEL;
                ADDR_W'(OFS_NOTIFY): sel = RS_NOTIFY;
                ADDR_W'(OFS_STATUS): sel = RS_STATUS;
                ADDR_W'(OFS_ISR):    sel = RS_ISR;
                default:             sel = RS_NONE;
            endcase
        end
    end

endmodule

// File: rtl/pvdev_features.sv
// pvdev_features: offered and accepted feature words.
// The offered word is the device input with the transport bits forced on.
// The accepted word is written by the guest; a write flagging a failed
// negotiation stores the fallback set instead. A device reset clears it.
module pvdev_features
    import pvdev_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        wr_en,
    input  logic [31:0] wdata,
    input  logic [31:0] dev_feat,
    input  logic [31:0] fallback,
    output logic [31:0] host_feat,
    output logic [31:0] guest_feat
);

    localparam logic [31:0] FORCED_BITS = (32'd1 << FBIT_NOTIFY_EMPTY)
                                        | (32'd1 << FBIT_INDIRECT)
                                        | (32'd1 << FBIT_BAD_NEG);

    logic [31:0] accepted_q;
    logic [31:0] accept_d;

    // Offered features: device bits plus the forced transport bits.
    assign host_feat = dev_feat | FORCED_BITS;

    // Value a guest write would store.
    assign accept_d = wdata[FBIT_BAD_NEG] ? fallback : wdata;

    // Accepted feature register with device-reset clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            accepted_q <= '0;
        end else if (wr_en) begin
            accepted_q <= accept_d;
        end
    end

    assign guest_feat = accepted_q;

    assert_badneg_fallback_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wdata[FBIT_BAD_NEG] && !clr) |=> (guest_feat == $past(fallback)));

    assert_plain_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wdata[FBIT_BAD_NEG] && !clr) |=> (guest_feat == $past(wdata)));

endmodule

// File: rtl/pvdev_queues.sv
// pvdev_queues: queue selector and per-queue ring page-number table.
// Assumes at most one bus access per cycle, so a selector write and a page
// write never coincide. Selector values at or above NQ are dropped.
// A device reset clears the selector and every page number in one cycle.
module pvdev_queues #(
    parameter int NQ     = 16,
    parameter int PAGE_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            sel_wr,
    input  logic [15:0]     sel_val,
    input  logic            page_wr,
    input  logic [PAGE_W-1:0] page_val,
    input  logic [16*NQ-1:0] qsize_flat,
    output logic [15:0]     sel_out,
    output logic [PAGE_W-1:0] sel_page,
    output logic [15:0]     sel_size
);

    localparam int QSEL_W = (NQ > 1) ? $clog2(NQ) : 1;

    logic [QSEL_W-1:0] sel_q;
    logic [PAGE_W-1:0] page_q [NQ];
    logic              sel_ok;

    // Selector write is legal only below the queue count.
    assign sel_ok = (32'(sel_val) < NQ);

    // Queue selector register.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            sel_q <= '0;
        end else if (sel_wr && sel_ok) begin
            sel_q <= sel_val[QSEL_W-1:0];
        end
    end

    // One page-number register per queue, written only when selected.
    for (genvar qi = 0; qi < NQ; qi++) begin : g_page
        always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
                page_q[qi] <= '0;
            end else if (page_wr && (sel_q == QSEL_W'(qi))) begin
                page_q[qi] <= page_val;
            end
        end
    end

    assign sel_out  = 16'(sel_q);
    assign sel_page = page_q[sel_q];
    assign sel_size = qsize_flat[16*sel_q +: 16];

    assert_sel_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(sel_q) < NQ));

    assert_sel_reject_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_wr && (32'(sel_val) >= NQ) && !clr) |=> $stable(sel_q));

    assert_page_store_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (page_wr && !clr) |=> (sel_page == $past(page_val)));

    assert_clear_all_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (sel_q == '0 && sel_page == '0));

endmodule

// File: rtl/pvdev_isr.sv
// pvdev_isr: interrupt status byte. Bit 0 records a used-buffer event.
// A read of the byte clears it at the end of that access, as does a device
// reset; an event in the same cycle wins over both. Upper bits stay zero.
module pvdev_isr (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       rd_clear,
    input  logic       used_evt,
    output logic [7:0] isr
);

    logic [7:0] isr_q;

    // Event set has priority over read-acknowledge and device reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            isr_q <= '0;
        end else if (used_evt) begin
            isr_q <= isr_q | 8'h01;
        end else if (rd_clear || clr) begin
            isr_q <= '0;
        end
    end

    assign isr = isr_q;

    assert_evt_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
        used_evt |=> isr[0]);

    assert_read_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clear && !used_evt) |=> (isr == 8'h00));

    assert_no_spurious_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!used_evt) |=> !$rose(isr[0]));

endmodule

// File: rtl/pvdev_regs.sv
// pvdev_regs: register block of a legacy paravirtual I/O device.
// Decodes one bus access per cycle, returns read data in the same cycle,
// forwards offsets from 20 up to an external configuration port, and drives
// the queue kick, the device reset pulse and the level interrupt.
// Assumes bus_wr and bus_rd are never high together.
module pvdev_regs
    import pvdev_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int NQ     = 16,
    parameter int PAGE_W = 32,
    parameter int PA_W   = PAGE_W + PAGE_SHIFT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [2:0]        bus_size,
    input  logic [31:0]       bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [31:0]       bus_rdata,
    input  logic [31:0]       dev_feat,
    input  logic [31:0]       fallback_feat,
    input  logic [16*NQ-1:0]  qsize_in,
    input  logic              used_evt,
    output logic [31:0]       feat_out,
    output logic [7:0]        dev_status,
    output logic              dev_reset,
    output logic [PA_W-1:0]   sel_qaddr,
    output logic              kick,
    output logic [15:0]       kick_q,
    output logic              irq,
    output logic [ADDR_W-1:0] cfg_addr,
    output logic [2:0]        cfg_size,
    output logic [31:0]       cfg_wdata,
    output logic              cfg_wr,
    output logic              cfg_rd,
    input  logic [31:0]       cfg_rdata
);

    reg_sel_e          rsel;
    logic              wr_guest, wr_page, wr_sel, wr_notify, wr_status;
    logic              rd_isr, dev_clr;
    logic [31:0]       host_feat, guest_feat;
    logic [15:0]       sel_idx, sel_size;
    logic [PAGE_W-1:0] sel_page;
    logic [7:0]        isr;
    logic [7:0]        status_q;
    logic              kick_q_r;
    logic [15:0]       kick_idx_q;
    logic              dev_reset_q;

    pvdev_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr (bus_addr),
        .sel  (rsel)
    );

    // Per-register write and read-side-effect strobes.
    assign wr_guest  = bus_wr && (rsel == RS_GUESTF);
    assign wr_page   = bus_wr && (rsel == RS_QPAGE);
    assign wr_sel    = bus_wr && (rsel == RS_QSEL);
    assign wr_notify = bus_wr && (rsel == RS_NOTIFY);
    assign wr_status = bus_wr && (rsel == RS_STATUS);
    assign rd_isr    = bus_rd && (rsel == RS_ISR);
    assign dev_clr   = wr_status && (bus_wdata[7:0] == 8'h00);

    pvdev_features u_feat (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (dev_clr),
        .wr_en      (wr_guest),
        .wdata      (bus_wdata),
        .dev_feat   (dev_feat),
        .fallback   (fallback_feat),
        .host_feat  (host_feat),
        .guest_feat (guest_feat)
    );

    pvdev_queues #(.NQ(NQ), .PAGE_W(PAGE_W)) u_queues (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (dev_clr),
        .sel_wr     (wr_sel),
        .sel_val    (bus_wdata[15:0]),
        .page_wr    (wr_page),
        .page_val   (bus_wdata[PAGE_W-1:0]),
        .qsize_flat (qsize_in),
        .sel_out    (sel_idx),
        .sel_page   (sel_page),
        .sel_size   (sel_size)
    );

    pvdev_isr u_isr (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (dev_clr),
        .rd_clear (rd_isr),
        .used_evt (used_evt),
        .isr      (isr)
    );

    // Device status byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= '0;
        end else if (wr_status) begin
            status_q <= bus_wdata[7:0];
        end
    end

    // One-cycle kick pulse and its queue index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kick_q_r   <= 1'b0;
            kick_idx_q <= '0;
        end else begin
            kick_q_r <= wr_notify;
            if (wr_notify) begin
                kick_idx_q <= bus_wdata[15:0];
            end
        end
    end

    // One-cycle pulse telling the device core it was reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dev_reset_q <= 1'b0;
        end else begin
            dev_reset_q <= dev_clr;
        end
    end

    // Read data multiplexer; unmapped offsets read as all ones.
    always_comb begin
        case (rsel)
            RS_HOSTF:  bus_rdata = host_feat;
            RS_GUESTF: bus_rdata = guest_feat;
            RS_QPAGE:  bus_rdata = 32'(sel_page);
            RS_QSIZE:  bus_rdata = 32'(sel_size);
            RS_QSEL:   bus_rdata = 32'(sel_idx);
            RS_STATUS: bus_rdata = 32'(status_q);
            RS_ISR:    bus_rdata = 32'(isr);
            RS_CFG:    bus_rdata = cfg_rdata;
            default:   bus_rdata = 32'hFFFF_FFFF;
        endcase
    end

    // Pass-through to the device-specific configuration area.
    assign cfg_addr  = bus_addr - ADDR_W'(OFS_CFG);
    assign cfg_size  = bus_size;
    assign cfg_wdata = bus_wdata;
    assign cfg_wr    = bus_wr && (rsel == RS_CFG);
    assign cfg_rd    = bus_rd && (rsel == RS_CFG);

    assign feat_out   = guest_feat;
    assign dev_status = status_q;
    assign dev_reset  = dev_reset_q;
    assign sel_qaddr  = {sel_page, {PAGE_SHIFT{1'b0}}};
    assign kick       = kick_q_r;
    assign kick_q     = kick_idx_q;
    assign irq        = isr[0];

    assert_kick_from_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        kick |-> ($past(bus_wr) && ($past(bus_addr) == ADDR_W'(OFS_NOTIFY))));

    assert_kick_index_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(OFS_NOTIFY)) |=> (kick && kick_q == $past(bus_wdata[15:0])));

    assert_reset_state_R7: assert property (@(posedge clk) disable iff (!rst_n)
        dev_reset |-> (dev_status == 8'h00 && feat_out == 32'h0));

    assert_cfg_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr < ADDR_W'(OFS_CFG)) |-> (!cfg_wr && !cfg_rd));

endmodule

// File: tb/pvdev_regs_test.sv
// Bench for pvdev_regs: a behavioural model updated on every rising edge and
// compared with every output on every falling edge.
`timescale 1ns/1ps
module pvdev_regs_test;

    localparam int NQ = 16;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [2:0]    bus_size = 3'd4;
    logic [31:0]   bus_wdata = '0;
    logic          bus_wr = 1'b0, bus_rd = 1'b0;
    logic [31:0]   bus_rdata;
    logic [31:0]   dev_feat = 32'h0000_0A5F;
    logic [31:0]   fallback_feat = 32'h0000_0011;
    logic [16*NQ-1:0] qsize_in;
    logic          used_evt = 1'b0;
    logic [31:0]   feat_out;
    logic [7:0]    dev_status;
    logic          dev_reset;
    logic [43:0]   sel_qaddr;
    logic          kick;
    logic [15:0]   kick_q;
    logic          irq;
    logic [AW-1:0] cfg_addr;
    logic [2:0]    cfg_size;
    logic [31:0]   cfg_wdata;
    logic          cfg_wr, cfg_rd;
    logic [31:0]   cfg_rdata;

    always #2 clk = ~clk;

    assign cfg_rdata = {24'hC0DE5A, cfg_addr};

    pvdev_regs uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_size(bus_size),
        .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .dev_feat(dev_feat), .fallback_feat(fallback_feat), .qsize_in(qsize_in),
        .used_evt(used_evt), .feat_out(feat_out), .dev_status(dev_status),
        .dev_reset(dev_reset), .sel_qaddr(sel_qaddr), .kick(kick), .kick_q(kick_q),
        .irq(irq), .cfg_addr(cfg_addr), .cfg_size(cfg_size), .cfg_wdata(cfg_wdata),
        .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_rdata(cfg_rdata)
    );

    // Reference model state.
    logic [31:0] m_guest;
    logic [31:0] m_page [NQ];
    int          m_sel;
    logic [7:0]  m_status, m_isr;
    logic        m_kick, m_devrst;
    logic [15:0] m_kq;

    int n_cmp = 0, n_bad = 0, cyc = 0;
    bit done = 0;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] exp_rdata(input int a);
        case (a)
            0:  return dev_feat | 32'h5100_0000;
            4:  return m_guest;
            8:  return m_page[m_sel];
            12: return 32'(qsize_in[16*m_sel +: 16]);
            14: return 32'(m_sel);
            18: return 32'(m_status);
            19: return 32'(m_isr);
            default: return (a >= 20) ? {24'hC0DE5A, 8'(a - 20)} : 32'hFFFF_FFFF;
        endcase
    endfunction

    function automatic string tag_of(input int a);
        case (a)
            0: return "R1"; 4: return "R2"; 8: return "R3"; 12: return "R5";
            14: return "R4"; 18: return "R7"; 19: return "R8";
            default: return (a >= 20) ? "R10" : "R11";
        endcase
    endfunction

    // Model update on the rising edge, from inputs driven after the edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_guest = '0; m_sel = 0; m_status = '0; m_isr = '0;
            m_kick = 0; m_devrst = 0; m_kq = '0;
            for (int i = 0; i < NQ; i++) m_page[i] = '0;
        end else begin
            m_kick = 0; m_devrst = 0;
            if (bus_wr) begin
                case (int'(bus_addr))
                    4:  m_guest = bus_wdata[30] ? fallback_feat : bus_wdata;
                    8:  m_page[m_sel] = bus_wdata;
                    14: if (int'(bus_wdata[15:0]) < NQ) m_sel = int'(bus_wdata[15:0]);
                    16: begin m_kick = 1; m_kq = bus_wdata[15:0]; end
                    18: begin
                        m_status = bus_wdata[7:0];
                        if (bus_wdata[7:0] == 8'h00) begin
                            m_guest = '0; m_sel = 0; m_isr = '0; m_devrst = 1;
                            for (int i = 0; i < NQ; i++) m_page[i] = '0;
                        end
                    end
                    default: ;
                endcase
            end
            if (bus_rd && bus_addr == 8'd19) m_isr = '0;
            if (used_evt) m_isr[0] = 1'b1;
        end
    end

    // Compare every output on the falling edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R8 irq", 64'(irq), 64'(m_isr[0]));
            chk("R6 kick", 64'(kick), 64'(m_kick));
            if (m_kick) chk("R6 kick_q", 64'(kick_q), 64'(m_kq));
            chk("R7 dev_reset", 64'(dev_reset), 64'(m_devrst));
            chk("R7 dev_status", 64'(dev_status), 64'(m_status));
            chk("R2 feat_out", 64'(feat_out), 64'(m_guest));
            chk("R3 sel_qaddr", 64'(sel_qaddr), {20'h0, m_page[m_sel], 12'h000});
            chk("R10 cfg_rd", 64'(cfg_rd), 64'(bus_rd && bus_addr >= 8'd20));
            chk("R10 cfg_wr", 64'(cfg_wr), 64'(bus_wr && bus_addr >= 8'd20));
            if (bus_addr >= 8'd20) begin
                chk("R10 cfg_addr", 64'(cfg_addr), 64'(bus_addr - 8'd20));
                chk("R10 cfg_size", 64'(cfg_size), 64'(bus_size));
                chk("R10 cfg_wdata", 64'(cfg_wdata), 64'(bus_wdata));
            end
            if (bus_rd) chk(tag_of(int'(bus_addr)), 64'(bus_rdata), 64'(exp_rdata(int'(bus_addr))));
        end
    end

    task automatic acc(input bit w, input bit r, input int a, input logic [31:0] d,
                       input logic [2:0] sz = 3'd4, input bit ev = 0);
        @(posedge clk); #1;
        bus_wr = w; bus_rd = r; bus_addr = AW'(a); bus_wdata = d; bus_size = sz; used_evt = ev;
    endtask

    task automatic idle(input bit ev = 0);
        acc(0, 0, 0, 32'h0, 3'd4, ev);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            done = 1;
            n_bad++;
            $display("FAIL R12 watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NQ; i++) qsize_in[16*i +: 16] = 16'h0100 + 16'(i * 3);
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R12: reset state at the ports.
        chk("R12 irq", 64'(irq), 64'h0);
        chk("R12 kick", 64'(kick), 64'h0);
        chk("R12 dev_reset", 64'(dev_reset), 64'h0);
        chk("R12 feat_out", 64'(feat_out), 64'h0);
        chk("R12 sel_qaddr", 64'(sel_qaddr), 64'h0);

        // R1: offered features, and a write there is ignored.
        acc(0, 1, 0, 0);
        acc(1, 0, 0, 32'hFFFF_FFFF);
        acc(0, 1, 0, 0);
        // R2: plain accept, then failed-negotiation fallback.
        acc(1, 0, 4, 32'h0000_0123);
        acc(0, 1, 4, 0);
        acc(1, 0, 4, 32'h4000_0F00);
        acc(0, 1, 4, 0);
        // R4/R3/R5: select, page write, readback.
        acc(1, 0, 14, 3);
        acc(1, 0, 8, 32'h000A_BCDE);
        acc(0, 1, 8, 0);
        acc(0, 1, 12, 0);
        acc(1, 0, 14, 20);
        acc(0, 1, 14, 0);
        acc(1, 0, 14, 15);
        acc(1, 0, 8, 32'hFFFF_F001);
        acc(1, 0, 14, NQ);
        acc(0, 1, 14, 0);
        acc(0, 1, 12, 0);
        acc(1, 0, 8, 32'h0000_0777);
        acc(1, 0, 14, 3);
        acc(0, 1, 8, 0);
        // R6: notify pulses.
        acc(1, 0, 16, 5);
        idle();
        acc(1, 0, 16, 32'h0001_000F);
        acc(1, 0, 16, 2);
        idle();
        // R8: event, read-clear, second read sees zero.
        idle(1);
        idle();
        acc(0, 1, 19, 0);
        acc(0, 1, 19, 0);
        // R9: event wins over same-cycle read-clear.
        acc(0, 1, 19, 0, 3'd1, 1);
        idle();
        @(negedge clk);
        chk("R9 irq after event+read", 64'(irq), 64'h1);
        acc(0, 1, 19, 0);
        // R7: status write, then zero status resets device.
        acc(1, 0, 18, 32'hFFFF_FF0F);
        acc(0, 1, 18, 0);
        acc(1, 0, 18, 32'h0000_0100);
        idle();
        acc(0, 1, 4, 0);
        acc(0, 1, 14, 0);
        acc(0, 1, 8, 0);
        // R9: event wins over zero-status reset.
        acc(1, 0, 4, 32'h55);
        acc(1, 0, 18, 0, 3'd1, 1);
        idle();
        @(negedge clk);
        chk("R9 irq after event+reset", 64'(irq), 64'h1);
        acc(0, 1, 19, 0);
        // R10: config pass-through, several sizes.
        acc(0, 1, 20, 0, 3'd4);
        acc(0, 1, 23, 0, 3'd2);
        acc(1, 0, 21, 32'hDEAD_BEEF, 3'd1);
        acc(0, 1, 255, 0, 3'd1);
        // R11: unmapped offsets.
        for (int a = 0; a < 20; a++) begin
            if (!(a inside {0, 4, 8, 12, 14, 16, 18, 19})) acc(0, 1, a, 0, 3'd1);
        end
        idle();
        idle();
        @(negedge clk);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule